// File: doc/BRIEF.md
# Fracturable Look-Up Table Cell with RAM and Shift Modes

This cell holds 64 storage bits and reads them through six address inputs. In logic mode it is one 6-input function on the main output. The same cycle also gives a second 5-input function on the auxiliary output. This works because the table is split into two 32-bit halves. The five low address bits index both halves. The top address bit picks which half drives the main output, and the auxiliary output always reads the lower half. Tie the top address bit high and the two outputs become two independent 5-input functions that share their inputs.

The table contents come in through a serial configuration port, one bit per clock. The same bits can also be reused at run time in three other ways:
- as a 64x1 RAM with a synchronous write;
- as a 32x2 RAM with a synchronous write;
- as a shift register of up to 32 stages, where the tap is chosen by address.

A 2-bit mode register selects the behaviour. Changing the mode leaves the stored bits unchanged. Every read is a plain multiplexer selection with no clock, so read delay is the same whatever the contents are.

Top module: `lutcell_frac`

## Requirements
- R1: While `rstN` is low, and after it is released, the mode is logic (code 00) and all 64 storage bits are 0, so both outputs read 0 at every address.
- R2: While `cfgEn` is high, each rising edge shifts `cfgBit` into bit 0 and moves every bit up one address. The first of 64 bits therefore ends at address 63. This load overrides any write or shift request in every mode.
- R3: In logic mode, `mainOut` equals the stored bit at address `addr[5:0]`, combinationally and with no clock.
- R4: In logic and 64x1 RAM modes, `auxOut` equals the lower-half bit at `addr[4:0]`, whatever `addr[5]` is. With `addr[5]` high the two outputs are two 5-input functions at the same time.
- R5: On a rising edge with `modeWe` high, `modeIn` is loaded into the mode register. The codes are 00 logic, 01 RAM 64x1, 10 RAM 32x2 and 11 shift. A mode change does not alter the storage.
- R6: In RAM 64x1 mode, a rising edge with `wrEn` high writes `din[0]` to address `addr[5:0]`. The new value can be read at once through `mainOut`.
- R7: In RAM 32x2 mode, a rising edge with `wrEn` high writes two bits into row `addr[4:0]`: `din[0]` into the lower half and `din[1]` into the upper half. `mainOut` reads the upper half and `auxOut` the lower half of row `addr[4:0]`, and `addr[5]` is ignored.
- R8: In shift mode, each rising edge with `shEn` high moves the lower 32 bits up one place and loads `din[0]` into bit 0. `mainOut` shows tap `addr[4:0]`, which is a delay of `addr[4:0]`+1 shifts, and `addr[5]` is ignored. `auxOut` shows bit 31. The upper half is unchanged.
- R9: `wrEn` has no effect in logic and shift modes. `shEn` has no effect in logic and RAM modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all storage and mode updates happen on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEn | input | 1 | Serial configuration load enable |
| cfgBit | input | 1 | Serial configuration data, highest address first |
| modeWe | input | 1 | Mode register load enable |
| modeIn | input | 2 | New mode code |
| addr | input | 6 | Lookup, RAM, or tap address |
| din | input | 2 | Write data for RAM modes; bit 0 is the shift input |
| wrEn | input | 1 | RAM write enable |
| shEn | input | 1 | Shift enable |
| mainOut | output | 1 | Main output: 6-input lookup, RAM read, or selected tap |
| auxOut | output | 1 | Auxiliary output: lower-half lookup, or last shift stage |

## Verification
The assertions assume the control inputs are low during reset. They also assume at most one kind of storage update is wanted at a time, with configuration load taking precedence. The bench changes inputs only on falling edges and holds every enable low while reset is active. It raises `wrEn` or `shEn` together with `cfgEn` only to check that the load has priority. It samples the combinational outputs a short delay after each address change, away from any clock edge.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

  typedef enum logic [1:0] {
    MODE_LOGIC   = 2'b00,
    MODE_RAM64   = 2'b01,
    MODE_RAM32X2 = 2'b10,
    MODE_SHIFT   = 2'b11
  } cellMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgShift;   // serial configuration step
    logic wrSingle;   // one-bit RAM write
    logic wrDual;     // two-bit RAM write
    logic shiftStep;  // shift-register step on the lower half
    logic pinTop;     // force read address MSB high
    logic pinBottom;  // force read address MSB low
    logic shiftView;  // aux output shows last shift stage
  } cellCtrl_t;

endpackage

// File: rtl/lutcell_ctrl.sv
module lutcell_ctrl
  import lutcell_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgEn,
  input  logic      modeWe,
  input  logic [1:0] modeIn,
  input  logic      wrEn,
  input  logic      shEn,
  output cellCtrl_t ctrl
);

  cellMode_e modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_LOGIC;
    end else if (modeWe) begin
      modeQ <= cellMode_e'(modeIn);
    end
  end

  always_comb begin
    ctrl           = '0;
    ctrl.cfgShift  = cfgEn;
    ctrl.wrSingle  = !cfgEn && wrEn && (modeQ == MODE_RAM64);
    ctrl.wrDual    = !cfgEn && wrEn && (modeQ == MODE_RAM32X2);
    ctrl.shiftStep = !cfgEn && shEn && (modeQ == MODE_SHIFT);
    ctrl.pinTop    = (modeQ == MODE_RAM32X2);
    ctrl.pinBottom = (modeQ == MODE_SHIFT);
    ctrl.shiftView = (modeQ == MODE_SHIFT);
  end

  AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.cfgShift, ctrl.wrSingle, ctrl.wrDual, ctrl.shiftStep})) else $error("update strobes overlap"); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !modeWe |=> $stable(modeQ)) else $error("mode changed without load"); // R5
  AST_READ_PIN_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.pinTop && ctrl.pinBottom)) else $error("read pins both set"); // R7

endmodule

// File: rtl/lutcell_datapath.sv
module lutcell_datapath
  import lutcell_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  cellCtrl_t         ctrl,
  input  logic              cfgBit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        din,
  output logic              mainOut,
  output logic              auxOut
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam int LOW_W = ADDR_W - 1;

  logic [DEPTH-1:0] mem;
  logic [DEPTH-1:0] memNext;
  logic [LOW_W-1:0] rowAddr;
  logic             readTop;

  assign rowAddr = addr[LOW_W-1:0];

  // Per-bit next-state selection
  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    localparam int ROW = i % HALF;
    logic chainSrc;
    logic hitSingle;
    logic hitDual;
    logic dualData;

    if (i == 0) begin : g_head
      assign chainSrc = 1'b0;
    end else begin : g_body
      assign chainSrc = mem[i-1];
    end

    assign hitSingle = ctrl.wrSingle && (addr == ADDR_W'(i));
    assign hitDual   = ctrl.wrDual && (rowAddr == LOW_W'(ROW));
    assign dualData  = (i >= HALF) ? din[1] : din[0];

    if (i < HALF) begin : g_low
      always_comb begin
        if (ctrl.cfgShift)       memNext[i] = (i == 0) ? cfgBit : chainSrc;
        else if (hitSingle)      memNext[i] = din[0];
        else if (hitDual)        memNext[i] = dualData;
        else if (ctrl.shiftStep) memNext[i] = (i == 0) ? din[0] : chainSrc;
        else                     memNext[i] = mem[i];
      end
    end else begin : g_high
      always_comb begin
        if (ctrl.cfgShift)  memNext[i] = chainSrc;
        else if (hitSingle) memNext[i] = din[0];
        else if (hitDual)   memNext[i] = dualData;
        else                memNext[i] = mem[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mem <= '0;
    else       mem <= memNext;
  end

  // Clockless read multiplexers
  always_comb begin
    if (ctrl.pinTop)         readTop = 1'b1;
    else if (ctrl.pinBottom) readTop = 1'b0;
    else                     readTop = addr[ADDR_W-1];
  end

  assign mainOut = mem[{readTop, rowAddr}];
  assign auxOut  = ctrl.shiftView ? mem[HALF-1] : mem[{1'b0, rowAddr}];

  AST_CFG_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cfgShift |=> mem[DEPTH-1:1] == $past(mem[DEPTH-2:0])) else $error("config chain broken"); // R2
  AST_CFG_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cfgShift |=> mem[0] == $past(cfgBit)) else $error("config entry bit lost"); // R2
  AST_SHIFT_TOP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftStep |=> mem[DEPTH-1:HALF] == $past(mem[DEPTH-1:HALF])) else $error("upper half disturbed"); // R8
  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftStep |=> mem[HALF-1:1] == $past(mem[HALF-2:0])) else $error("shift chain broken"); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.cfgShift || ctrl.wrSingle || ctrl.wrDual || ctrl.shiftStep) |=> $stable(mem)) else $error("storage changed while idle"); // R9

endmodule

// File: rtl/lutcell_frac.sv
module lutcell_frac
  import lutcell_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEn,
  input  logic              cfgBit,
  input  logic              modeWe,
  input  logic [1:0]        modeIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        din,
  input  logic              wrEn,
  input  logic              shEn,
  output logic              mainOut,
  output logic              auxOut
);

  cellCtrl_t ctrl;

  lutcell_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgEn  (cfgEn),
    .modeWe (modeWe),
    .modeIn (modeIn),
    .wrEn   (wrEn),
    .shEn   (shEn),
    .ctrl   (ctrl)
  );

  lutcell_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .cfgBit  (cfgBit),
    .addr    (addr),
    .din     (din),
    .mainOut (mainOut),
    .auxOut  (auxOut)
  );

endmodule

// File: tb/test_lutcell_frac.sv
module test_lutcell_frac;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] CFG = 64'hAAAA_AAAA_0F0F_0F0F;
  localparam int NVEC = 12;
  // {addr[5:0], expected mainOut, expected auxOut}
  localparam logic [7:0] VEC [NVEC] = '{
    {6'd0,  1'b1, 1'b1}, {6'd5,  1'b0, 1'b0}, {6'd33, 1'b1, 1'b1},
    {6'd36, 1'b0, 1'b0}, {6'd43, 1'b1, 1'b1}, {6'd47, 1'b1, 1'b0},
    {6'd2,  1'b1, 1'b1}, {6'd62, 1'b0, 1'b0}, {6'd35, 1'b1, 1'b1},
    {6'd40, 1'b0, 1'b1}, {6'd63, 1'b1, 1'b0}, {6'd24, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEn = 1'b0, cfgBit = 1'b0, modeWe = 1'b0, wrEn = 1'b0, shEn = 1'b0;
  logic [1:0] modeIn = 2'b00;
  logic [5:0] addr = '0;
  logic [1:0] din = '0;
  logic mainOut, auxOut;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lutcell_frac i_lutcell_frac (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgBit(cfgBit), .modeWe(modeWe),
    .modeIn(modeIn), .addr(addr), .din(din), .wrEn(wrEn), .shEn(shEn),
    .mainOut(mainOut), .auxOut(auxOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic readAt(input logic [5:0] a);
    addr = a;
    #1;
  endtask

  task automatic setMode(input logic [1:0] m);
    modeIn = m; modeWe = 1'b1;
    @(negedge clk);
    modeWe = 1'b0;
  endtask

  task automatic writeAt(input logic [5:0] a, input logic [1:0] d);
    addr = a; din = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic shiftIn(input logic b, input int n);
    din = {1'b0, b}; shEn = 1'b1;
    for (int k = 0; k < n; k++) @(negedge clk);
    shEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    readAt(6'd0);  check("R1 main@0", mainOut, 1'b0); check("R1 aux@0", auxOut, 1'b0);
    readAt(6'd63); check("R1 main@63", mainOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    readAt(6'd63); check("R1 main@63 after release", mainOut, 1'b0);

    // R2: load in RAM64 mode with a competing write; the load must win
    setMode(2'b01);
    addr = 6'd5; din = 2'b11; wrEn = 1'b1; cfgEn = 1'b1;
    for (int i = 63; i >= 0; i--) begin
      cfgBit = CFG[i];
      @(negedge clk);
    end
    cfgEn = 1'b0; wrEn = 1'b0;
    readAt(6'd5);  check("R2 load beats write @5", mainOut, 1'b0);
    readAt(6'd63); check("R2 first bit at top", mainOut, 1'b1);

    // R3/R4: logic-mode table walk
    setMode(2'b00);
    for (int v = 0; v < NVEC; v++) begin
      readAt(VEC[v][7:2]);
      check("R3 lookup", mainOut, VEC[v][1]);
      check("R4 aux half", auxOut, VEC[v][0]);
    end

    // R9: write and shift requests ignored in logic mode
    writeAt(6'd0, 2'b00);
    addr = 6'd4; shiftIn(1'b1, 1);
    readAt(6'd0); check("R9 wrEn ignored in logic", mainOut, 1'b1);
    readAt(6'd4); check("R9 shEn ignored in logic @4", mainOut, 1'b0);
    readAt(6'd3); check("R9 shEn ignored in logic @3", mainOut, 1'b1);

    // R5/R6: RAM64 mode keeps contents, then writes
    setMode(2'b01);
    readAt(6'd33); check("R5 contents kept", mainOut, 1'b1);
    writeAt(6'd5, 2'b01);
    writeAt(6'd33, 2'b00);
    readAt(6'd5);  check("R6 write 1 @5", mainOut, 1'b1); check("R4 aux ram64 @5", auxOut, 1'b1);
    readAt(6'd33); check("R6 write 0 @33", mainOut, 1'b0); check("R4 aux ram64 @33", auxOut, 1'b1);

    // R7: RAM32x2 two-bit write
    setMode(2'b10);
    writeAt(6'd2, 2'b10);
    readAt(6'd2);  check("R7 upper row2", mainOut, 1'b1); check("R7 lower row2", auxOut, 1'b0);
    readAt(6'd34); check("R7 msb ignored main", mainOut, 1'b1); check("R7 msb ignored aux", auxOut, 1'b0);
    readAt(6'd3);  check("R7 row3 upper", mainOut, 1'b1); check("R7 row3 lower", auxOut, 1'b1);

    // R8/R9: shift mode
    setMode(2'b11);
    writeAt(6'd40, 2'b01);
    shiftIn(1'b0, 32);
    shiftIn(1'b1, 1);
    shiftIn(1'b0, 4);
    readAt(6'd4); check("R8 tap4 holds bit", mainOut, 1'b1); check("R8 last stage low", auxOut, 1'b0);
    readAt(6'd3); check("R8 tap3 empty", mainOut, 1'b0);
    shiftIn(1'b0, 27);
    readAt(6'd31); check("R8 tap31", mainOut, 1'b1); check("R8 last stage", auxOut, 1'b1);
    readAt(6'd63); check("R8 msb ignored", mainOut, 1'b1);

    // R5/R8/R9: back to logic, inspect both halves
    setMode(2'b00);
    readAt(6'd40); check("R9 wrEn ignored in shift", mainOut, 1'b0);
    readAt(6'd34); check("R8 upper half kept", mainOut, 1'b1);
    readAt(6'd33); check("R5 ram64 write kept", mainOut, 1'b0);
    readAt(6'd31); check("R8 lower half shifted", mainOut, 1'b1);
    readAt(6'd5);  check("R8 lower half cleared", mainOut, 1'b0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule